// File: doc/BRIEF.md
# Multi-Line Write Cache Sequencer

This block sits between the byte-level side of a two-wire serial memory slave and its non-volatile storage array. During one write transaction, each data byte the interface receives is placed in a 64-byte cache. The cache holds eight lines of eight bytes. Bytes whose word addresses share the upper nine bits fall into the same line. Each line has a per-byte valid mask, so the array locations of bytes that were never sent are left as they are.

When the interface reports the closing STOP, the sequencer enters a self-timed programming phase. It commits the loaded lines one after another, in the order in which each line was first touched. Every line takes exactly `PROG_TICKS` clock cycles. During the first eight cycles of that period, each valid byte is written to the array port at the cycle matching its offset. While the phase runs, `busy` stays high, and the interface uses it to withhold acknowledges. When the last line finishes, the cache is emptied and `busy` falls.

The controller has two states. `ST_GATHER` collects bytes and `ST_BURN` programs lines. There are three transitions:
- `ST_GATHER` to `ST_BURN` (named *launch*) fires on a STOP while at least one line is loaded.
- `ST_BURN` to `ST_BURN` (named *advance*) fires at the end of a line period when more lines remain.
- `ST_BURN` to `ST_GATHER` (named *retire*) fires at the end of the last line's period and empties the cache.

`PROG_TICKS` must be at least `LINE_BYTES`.

Top module: `wcache_seq`

## Requirements
- R1: A byte's line tag is word-address bits [11:3] and its offset within the line is bits [2:0]. All bytes with the same tag in one transaction share one cache line, and the number of lines committed equals the number of distinct tags received, capped at eight.
- R2: Only bytes actually received are written to the array, and every other location keeps its previous content. When one address is written twice in a transaction, the later byte is the one committed.
- R3: `busy` rises in the cycle after a STOP is sampled with at least one byte cached. It then stays high for exactly (lines loaded) × `PROG_TICKS` consecutive cycles.
- R4: When all eight lines are in use and a byte arrives for a ninth distinct tag, a line is replaced in round-robin order, starting with the oldest slot (slot 0). The replaced line's earlier bytes are discarded, and the new tag takes over that slot's position in the commit order.
- R5: Lines are committed in slot order, which is first-load order. Within a line's period, the byte at offset k is written in cycle k of that period, counting from 0.
- R6: A STOP with no byte cached leaves `busy` low. A START strobe while idle discards everything cached by an unfinished transaction.
- R7: While `busy` is high, byte writes, START strobes and STOP strobes are ignored.
- R8: After the last line is programmed the cache is empty, so the next transaction commits only its own bytes.
- R9: `arr_we` is asserted only while `busy` is high, and at most once per cached valid byte.
- R10: A byte presented in the same cycle as a STOP or a START strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle strobe: a new transaction began (START seen) |
| xfer_stop | input | 1 | One-cycle strobe: the transaction closed with a STOP |
| byte_we | input | 1 | One-cycle strobe: a data byte was received |
| byte_addr | input | 12 | Word address of the received byte |
| byte_data | input | 8 | Received data byte |
| arr_we | output | 1 | Array write enable, one byte per cycle |
| arr_addr | output | 12 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Programming phase in progress; the interface must not acknowledge |

## Verification
The assertions assume that every strobe is a single-cycle pulse, that `PROG_TICKS` is at least the line length, and that the line count is a power of two. They also assume that the interface may keep driving strobes while `busy` is high, and the block must then ignore them. The bench drives all strobes as one-cycle pulses at the falling edge. It deliberately drives byte writes and STOP/START strobes during programming, and it picks random addresses inside narrow windows of tags, so that line hits, partial lines and the nine-tag replacement case all occur.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

    // Controller states: collect bytes, then program lines.
    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_BURN   = 1'b1
    } seq_state_t;

endpackage

// File: rtl/wcache_lines.sv
// Line storage: tags, per-byte valid masks, data, and slot allocation.
module wcache_lines #(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - OFF_W,
    localparam int SLOT_W    = $clog2(LINES),
    localparam int CNT_W     = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_byte,
    output logic [CNT_W-1:0]  used_cnt
);

    logic [TAG_W-1:0]      tag_q  [LINES];
    logic [LINE_BYTES-1:0] mask_q [LINES];
    logic [DATA_W-1:0]     data_q [LINES][LINE_BYTES];
    logic [CNT_W-1:0]      used_q;
    logic [SLOT_W-1:0]     repl_q;

    logic [TAG_W-1:0]  wr_tag;
    logic [OFF_W-1:0]  wr_off;
    logic [LINES-1:0]  hit_vec;
    logic              hit;
    logic [SLOT_W-1:0] hit_idx;
    logic [SLOT_W-1:0] tgt;
    logic              full;

    assign wr_tag = wr_addr[ADDR_W-1:OFF_W];
    assign wr_off = wr_addr[OFF_W-1:0];
    assign full   = (used_q == CNT_W'(LINES));

    // One tag comparator per slot, qualified by slot occupancy.
    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign hit_vec[i] = (CNT_W'(i) < used_q) && (tag_q[i] == wr_tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        if (hit)       tgt = hit_idx;
        else if (full) tgt = repl_q;
        else           tgt = used_q[SLOT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
            repl_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= '0;
                mask_q[i] <= '0;
            end
        end else if (clr) begin
            used_q <= '0;
            repl_q <= '0;
            for (int i = 0; i < LINES; i++) mask_q[i] <= '0;
        end else if (wr_en) begin
            if (hit) begin
                mask_q[tgt][wr_off] <= 1'b1;
            end else begin
                tag_q[tgt]  <= wr_tag;
                mask_q[tgt] <= LINE_BYTES'(1) << wr_off;
                if (full) repl_q <= repl_q + 1'b1;
                else      used_q <= used_q + 1'b1;
            end
        end
    end

    // Data storage needs no reset: the valid masks qualify every byte.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) data_q[tgt][wr_off] <= wr_data;
    end

    assign rd_tag   = tag_q[rd_slot];
    assign rd_valid = mask_q[rd_slot][rd_off];
    assign rd_byte  = data_q[rd_slot][rd_off];
    assign used_cnt = used_q;

endmodule

// File: rtl/wcache_tick.sv
// Line period timer: counts 0..PROG_TICKS-1 while run is high.
module wcache_tick #(
    parameter int PROG_TICKS = 24,
    localparam int PH_W      = $clog2(PROG_TICKS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [PH_W-1:0] phase,
    output logic            wrap
);

    logic [PH_W-1:0] ph_q;

    assign wrap  = run && (ph_q == PH_W'(PROG_TICKS - 1));
    assign phase = ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ph_q <= '0;
        else if (!run)  ph_q <= '0;
        else if (wrap)  ph_q <= '0;
        else            ph_q <= ph_q + 1'b1;
    end

endmodule

// File: rtl/wcache_seq.sv
// Top: gathers a transaction's bytes, then programs lines on STOP.
module wcache_seq #(
    parameter int PROG_TICKS = 24,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              byte_we,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              busy
);
    import wcache_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int SLOT_W = $clog2(LINES);
    localparam int CNT_W  = $clog2(LINES + 1);
    localparam int PH_W   = $clog2(PROG_TICKS + 1);

    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;

    logic [CNT_W-1:0]  lines_used;
    logic [PH_W-1:0]   tick_phase;
    logic              tick_wrap;
    logic              tick_run;
    logic              last_line;
    logic              store_clr;
    logic              store_wr;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_byte;
    logic [OFF_W-1:0]  cur_off;

    assign cur_off   = tick_phase[OFF_W-1:0];
    assign last_line = ({1'b0, slot_q} == (lines_used - CNT_W'(1)));

    wcache_lines #(
        .LINES(LINES), .LINE_BYTES(LINE_BYTES),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .clr(store_clr), .wr_en(store_wr),
        .wr_addr(byte_addr), .wr_data(byte_data),
        .rd_slot(slot_q), .rd_off(cur_off),
        .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .used_cnt(lines_used)
    );

    wcache_tick #(.PROG_TICKS(PROG_TICKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(tick_run),
        .phase(tick_phase), .wrap(tick_wrap)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next state: launch, advance, retire.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_GATHER: begin
                if (xfer_stop && (lines_used != '0)) begin
                    state_d = ST_BURN;
                    slot_d  = '0;
                end
            end
            ST_BURN: begin
                if (tick_wrap) begin
                    if (last_line) begin
                        state_d = ST_GATHER;
                        slot_d  = '0;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_GATHER;
        endcase
    end

    // Outputs and internal controls.
    always_comb begin
        busy      = 1'b0;
        tick_run  = 1'b0;
        store_clr = 1'b0;
        store_wr  = 1'b0;
        arr_we    = 1'b0;
        unique case (state_q)
            ST_GATHER: begin
                store_clr = xfer_start && !xfer_stop;
                store_wr  = byte_we && !xfer_start && !xfer_stop;
            end
            ST_BURN: begin
                busy      = 1'b1;
                tick_run  = 1'b1;
                store_clr = tick_wrap && last_line;
                arr_we    = (tick_phase < PH_W'(LINE_BYTES)) && rd_valid;
            end
            default: ;
        endcase
    end

    assign arr_addr = {rd_tag, cur_off};
    assign arr_data = rd_byte;

endmodule

// File: rtl/wcache_seq_chk.sv
// Property checker for wcache_seq, attached by bind below.
module wcache_seq_chk #(
    parameter int PROG_TICKS = 24,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CNT_W     = $clog2(LINES + 1),
    localparam int PH_W      = $clog2(PROG_TICKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             xfer_stop,
    input logic             arr_we,
    input logic [OFF_W-1:0] arr_off,
    input logic [CNT_W-1:0] lines,
    input logic [PH_W-1:0]  phase
);

    int unsigned busy_len;
    int unsigned lines_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len  <= 0;
            lines_cap <= 0;
        end else begin
            busy_len <= busy ? busy_len + 1 : 0;
            if (!busy) lines_cap <= 32'(lines);
        end
    end

    a_r9_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xfer_stop && lines != '0) |=> busy);

    a_r6_empty_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xfer_stop && lines == '0) |=> !busy);

    a_r7_lines_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (lines == $past(lines)) || (lines == '0));

    a_r5_offset_follows_phase: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (phase < PH_W'(LINE_BYTES)) && (arr_off == phase[OFF_W-1:0]));

    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == lines_cap * PROG_TICKS));

    a_r8_empty_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lines == '0));

endmodule

bind wcache_seq wcache_seq_chk #(
    .PROG_TICKS(PROG_TICKS), .LINES(LINES), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .xfer_stop(xfer_stop),
    .arr_we(arr_we), .arr_off(arr_addr[OFF_W-1:0]),
    .lines(lines_used), .phase(tick_phase)
);

// File: tb/wcache_seq_tb.sv
module wcache_seq_tb;
    localparam int PT = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_stop = 1'b0, byte_we = 1'b0;
    logic [11:0] byte_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        arr_we, busy;
    logic [11:0] arr_addr;
    logic [7:0]  arr_data;

    always #5 clk = ~clk;

    wcache_seq #(.PROG_TICKS(PT)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .byte_we(byte_we), .byte_addr(byte_addr), .byte_data(byte_data),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy)
    );

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // Array models: one fed by the DUT port, one by the bench reference.
    logic [7:0] mem_dut [4096];
    logic [7:0] mem_ref [4096];
    logic [8:0] obs_tag [16];
    int obs_n = 0, obs_wr = 0;

    always @(negedge clk) begin
        if (arr_we) begin
            mem_dut[arr_addr] <= arr_data;
            if (obs_n == 0 || obs_tag[obs_n-1] != arr_addr[11:3]) begin
                if (obs_n < 16) obs_tag[obs_n] <= arr_addr[11:3];
                obs_n <= obs_n + 1;
            end
            obs_wr <= obs_wr + 1;
        end
    end

    // Reference cache built from the requirements.
    logic [8:0] r_tag [8];
    logic [7:0] r_mask [8];
    logic [7:0] r_dat [8][8];
    int r_used = 0, r_rp = 0;

    task automatic ref_clear();
        r_used = 0; r_rp = 0;
        for (int i = 0; i < 8; i++) r_mask[i] = '0;
    endtask

    task automatic ref_write(input logic [11:0] a, input logic [7:0] d);
        int s = -1;
        for (int i = 0; i < r_used; i++) if (r_tag[i] == a[11:3]) s = i;
        if (s < 0) begin
            if (r_used < 8) begin s = r_used; r_used++; end
            else begin s = r_rp; r_rp = (r_rp + 1) % 8; end
            r_tag[s] = a[11:3];
            r_mask[s] = '0;
        end
        r_mask[s][a[2:0]] = 1'b1;
        r_dat[s][a[2:0]] = d;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); byte_we = 1'b1; byte_addr = a; byte_data = d;
        @(negedge clk); byte_we = 1'b0;
        ref_write(a, d);
    endtask

    task automatic begin_txn();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        ref_clear();
    endtask

    // Issue STOP (optionally with a same-cycle byte), time busy, compare.
    task automatic commit(input string req, input bit noisy, input bit tail_byte);
        int n = 0, exp_wr = 0, bad = 0, ord_bad = 0;
        obs_n = 0; obs_wr = 0;
        @(negedge clk); xfer_stop = 1'b1;
        if (tail_byte) begin byte_we = 1'b1; byte_addr = 12'hE05; byte_data = 8'h77; end
        @(negedge clk); xfer_stop = 1'b0; byte_we = 1'b0;
        while (busy && n < 5000) begin
            n++;
            if (noisy) begin
                byte_we = 1'b1; byte_addr = 12'(  $urandom); byte_data = 8'h5A;
                xfer_stop = n[0]; xfer_start = n[1];
            end
            @(negedge clk);
        end
        byte_we = 1'b0; xfer_stop = 1'b0; xfer_start = 1'b0;
        @(negedge clk);
        check(n == r_used * PT, {req, " R3 busy cycles"}, n, r_used * PT);
        for (int s = 0; s < r_used; s++)
            for (int k = 0; k < 8; k++)
                if (r_mask[s][k]) begin
                    mem_ref[{r_tag[s], 3'(k)}] = r_dat[s][k];
                    exp_wr++;
                end
        for (int i = 0; i < 4096; i++) if (mem_dut[i] !== mem_ref[i]) bad++;
        check(bad == 0, {req, " R2 array contents"}, bad, 0);
        if (obs_n != r_used) ord_bad = 1;
        else for (int s = 0; s < r_used; s++) if (obs_tag[s] != r_tag[s]) ord_bad = 1;
        check(ord_bad == 0, {req, " R5 commit order"}, obs_n, r_used);
        check(obs_wr == exp_wr, {req, " R9 write count"}, obs_wr, exp_wr);
        ref_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) begin mem_dut[i] = '0; mem_ref[i] = '0; end
        ref_clear();
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R9 reset state idle", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3: single byte, one line.
        begin_txn(); send_byte(12'h123, 8'hC3); commit("R1 single", 0, 0);

        // R2: full line, then partial rewrite with a repeated address.
        begin_txn();
        for (int k = 0; k < 8; k++) send_byte(12'h200 + 12'(k), 8'hAA);
        commit("R2 fill", 0, 0);
        begin_txn();
        send_byte(12'h202, 8'h11); send_byte(12'h207, 8'h22); send_byte(12'h202, 8'h33);
        commit("R2 partial", 0, 0);

        // R5: eight lines touched in scrambled order, revisiting earlier lines.
        begin_txn();
        for (int i = 0; i < 8; i++) send_byte({9'(40 + ((i * 5) % 8)), 3'(i)}, 8'(i + 1));
        send_byte({9'd40, 3'd7}, 8'h99);
        commit("R5 order", 0, 0);

        // R4: ten distinct tags force two round-robin replacements.
        begin_txn();
        for (int i = 0; i < 10; i++) send_byte({9'(100 + i), 3'd1}, 8'(16 + i));
        send_byte({9'd101, 3'd2}, 8'hEE);
        commit("R4 wrap", 0, 0);

        // R6: STOP with nothing cached keeps busy low.
        begin_txn();
        @(negedge clk); xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R6 empty stop", int'(busy), 0);

        // R6: transaction without STOP is discarded by the next START.
        begin_txn(); send_byte(12'h300, 8'h01); send_byte(12'h318, 8'h02);
        begin_txn(); send_byte(12'h400, 8'h03);
        commit("R6 discard", 0, 0);

        // R7: strobes and bytes during programming are ignored; R8 afterwards.
        begin_txn(); send_byte(12'h500, 8'h44); send_byte(12'h510, 8'h45);
        commit("R7 noisy", 1, 0);
        begin_txn(); send_byte(12'h600, 8'h46);
        commit("R8 fresh", 0, 0);

        // R10: byte in the same cycle as STOP is dropped.
        begin_txn(); send_byte(12'h700, 8'h47);
        commit("R10 stop byte", 0, 1);

        // Random transactions in narrow tag windows.
        for (int t = 0; t < 30; t++) begin
            int nb = 1 + int'($urandom % 70);
            int base = int'($urandom % 500);
            int span = 2 + int'($urandom % 11);
            begin_txn();
            for (int b = 0; b < nb; b++)
                send_byte({9'(base + int'($urandom % span)), 3'($urandom)}, 8'($urandom));
            commit("R1 random", (t % 4) == 0, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule